// File: doc/BRIEF.md
# Coin Credit Vend Controller

This controller tracks the money a customer has put into a single coin slot that takes nickels (5 cents) and dimes (10 cents), and signals release of one item once the credit reaches the 15-cent price. Credit saturates at 15 cents. Any overpayment is absorbed, and no change is returned. Once paid, the machine stays in the paid state until a reset clears it.

Each coin arrives as a one-cycle pulse on its own input, and the credit moves on at the next clock edge. Two release signals are provided. The first depends only on the stored credit and is high for as long as the 15-cent state is held. The second also looks at the coin inputs in the current cycle, so it rises in the same cycle as the coin that completes the price. The coin pulses and the reset are plain control pins, with no handshake.

The credit is held in two bits. A fixed binary code stands for each amount, and the next state comes from minimised sum-of-product equations. The input combination in which both coins are present should never occur. If it does occur, the controller counts it as a dime.

Top module: `coin_vend_ctrl`

## Requirements
- R1: Reset is synchronous and active high, and it overrides the coin inputs. After any clock edge at which reset is high, the credit is 0 cents. While reset is high, the combinational release output is 0.
- R2: In a cycle with no coin and no reset, the credit keeps its value across the clock edge.
- R3: A nickel alone adds 5 cents at the next edge. It takes 0 to 5, 5 to 10 and 10 to 15.
- R4: A dime adds 10 cents at the next edge. It takes 0 to 10. From 5 or 10 cents it takes the credit to 15, with no change given.
- R5: Without reset, the 15-cent state is held whatever the coin inputs are.
- R6: credit_o shows the credit with this code: 2'b00 is 0 cents, 2'b01 is 5 cents, 2'b10 is 10 cents and 2'b11 is 15 cents.
- R7: paid_state_o is 1 exactly when the credit is 15 cents. It depends on the registered state only.
- R8: paid_now_o is 1 in the same cycle, before the edge, when reset is low and one of these holds: the credit is 15 cents; the credit is 5 cents and a dime is present; the credit is 10 cents and any coin is present.
- R9: When the nickel and dime inputs are both 1 in the same cycle, the next state and paid_now_o are the same as for a dime alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nickel_i | input | 1 | One-cycle pulse: a 5-cent coin was accepted |
| dime_i | input | 1 | One-cycle pulse: a 10-cent coin was accepted |
| credit_o | output | 2 | Registered credit code |
| paid_state_o | output | 1 | Release, decoded from the state only |
| paid_now_o | output | 1 | Release, decoded from the state and the coin inputs |

## Verification
The bench goes through every credit state with every pair of coin inputs, including the pair that should never occur, and then runs a long pseudo-random coin stream with occasional resets, comparing each output against an arithmetic model of the credit. Saturation is the main corner case. A design that wraps past 15 cents would go back to a low credit after a dime at 10 cents, or after any coin at 15 cents. If the two coins at once were not mapped to a dime, the raw equations would jump from 0 to 15 cents. A combinational release output that waited for the state to change would be one cycle late on the completing coin. A reset that did not win over a coin arriving in the same cycle would leave credit behind.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int unsigned CREDIT_W = 2;

  typedef enum logic [CREDIT_W-1:0] {
    CR_0C  = 2'b00,
    CR_5C  = 2'b01,
    CR_10C = 2'b10,
    CR_15C = 2'b11
  } credit_t;

  typedef struct packed {
    logic nickel;
    logic dime;
  } coin_t;
endpackage

// File: rtl/vend_coin_filter.sv
module vend_coin_filter
  import vend_pkg::*;
(
  input  logic  nickel_raw,
  input  logic  dime_raw,
  output coin_t coin
);
  // a simultaneous pair is resolved in favour of the dime
  always_comb begin
    coin.dime   = dime_raw;
    coin.nickel = nickel_raw & ~dime_raw;
  end
endmodule

// File: rtl/vend_next_state.sv
module vend_next_state
  import vend_pkg::*;
(
  input  credit_t cur,
  input  coin_t   coin,
  output credit_t nxt
);
  logic q1, q0, n, d, d1, d0;

  always_comb begin
    q1 = cur[1];
    q0 = cur[0];
    n  = coin.nickel;
    d  = coin.dime;
    d1 = q1 | d | (q0 & n);
    d0 = (n & ~q0) | (q0 & ~n) | (q1 & n) | (q1 & d);
    nxt = credit_t'({d1, d0});
  end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  credit_t nxt,
  output credit_t cur
);
  always_ff @(posedge clk) begin
    if (rst) cur <= CR_0C;
    else     cur <= nxt;
  end
endmodule

// File: rtl/vend_release_decode.sv
module vend_release_decode
  import vend_pkg::*;
(
  input  logic    rst,
  input  credit_t cur,
  input  coin_t   coin,
  output logic    paid_state,
  output logic    paid_now
);
  always_comb begin
    paid_state = cur[1] & cur[0];
    paid_now   = ~rst & ((cur[1] & cur[0])
                       | (coin.dime & (cur[1] | cur[0]))
                       | (coin.nickel & cur[1]));
  end
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import vend_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                nickel_i,
  input  logic                dime_i,
  output logic [CREDIT_W-1:0] credit_o,
  output logic                paid_state_o,
  output logic                paid_now_o
);
  coin_t   coin;
  credit_t cur, nxt;

  vend_coin_filter u_filter (
    .nickel_raw (nickel_i),
    .dime_raw   (dime_i),
    .coin       (coin)
  );

  vend_next_state u_next (
    .cur  (cur),
    .coin (coin),
    .nxt  (nxt)
  );

  vend_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .cur (cur)
  );

  vend_release_decode u_dec (
    .rst        (rst),
    .cur        (cur),
    .coin       (coin),
    .paid_state (paid_state_o),
    .paid_now   (paid_now_o)
  );

  assign credit_o = cur;
endmodule

// File: rtl/vend_checker.sv
module vend_checker (
  input logic       clk,
  input logic       rst,
  input logic       nickel_i,
  input logic       dime_i,
  input logic [1:0] credit_o,
  input logic       paid_state_o,
  input logic       paid_now_o
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> credit_o == 2'b00);

  // R1
  always @(posedge clk) begin
    if (rst) begin
      reset_quiet_chk: assert (!paid_now_o);
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!nickel_i && !dime_i) |=> $stable(credit_o));

  // R3
  nickel_step_chk: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && !dime_i && credit_o != 2'b11) |=> credit_o == $past(credit_o) + 2'b01);

  // R4
  dime_from_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (dime_i && credit_o == 2'b00) |=> credit_o == 2'b10);

  // R5
  paid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (credit_o == 2'b11) |=> credit_o == 2'b11);

  // R7
  moore_decode_chk: assert property (@(posedge clk) disable iff (rst)
    paid_state_o == (credit_o == 2'b11));

  // R8
  mealy_paid_chk: assert property (@(posedge clk) disable iff (rst)
    (credit_o == 2'b11) |-> paid_now_o);

  // R9
  both_as_dime_chk: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && dime_i && credit_o == 2'b01) |-> paid_now_o ##1 credit_o == 2'b11);
endmodule

bind coin_vend_ctrl vend_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .nickel_i     (nickel_i),
  .dime_i       (dime_i),
  .credit_o     (credit_o),
  .paid_state_o (paid_state_o),
  .paid_now_o   (paid_now_o)
);

// File: tb/sim_coin_vend_ctrl.sv
module sim_coin_vend_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       nickel_i = 1'b0;
  logic       dime_i = 1'b0;
  logic [1:0] credit_o;
  logic       paid_state_o;
  logic       paid_now_o;

  int checks = 0;
  int fails  = 0;
  int model  = 0; // credit in nickels: 0..3

  always #2 clk = ~clk; // 250 MHz

  coin_vend_ctrl u0 (
    .clk          (clk),
    .rst          (rst),
    .nickel_i     (nickel_i),
    .dime_i       (dime_i),
    .credit_o     (credit_o),
    .paid_state_o (paid_state_o),
    .paid_now_o   (paid_now_o)
  );

  function automatic int next_credit(int c, bit n, bit d, bit r);
    int s;
    if (r) return 0;
    s = c + (d ? 2 : (n ? 1 : 0));
    return (s > 3) ? 3 : s;
  endfunction

  function automatic bit exp_now(int c, bit n, bit d, bit r);
    if (r) return 1'b0;
    return (c == 3) || (d && c >= 1) || (n && !d && c >= 2);
  endfunction

  function automatic string tag_of(int c, bit n, bit d, bit r);
    if (r) return "R1";
    if (c == 3) return "R5";
    if (n && d) return "R9";
    if (d) return "R4";
    if (n) return "R3";
    return "R2";
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit n, bit d, bit r);
    string t;
    @(negedge clk);
    nickel_i = n;
    dime_i   = d;
    rst      = r;
    #1;
    t = tag_of(model, n, d, r);
    if (r) check("R1 paid_now in reset", paid_now_o, 0);
    else check({"R8 paid_now ", t}, paid_now_o, exp_now(model, n, d, r));
    @(posedge clk);
    #1;
    model = next_credit(model, n, d, r);
    check({t, "/R6 credit"}, credit_o, model);
    check("R7 paid_state", paid_state_o, model == 3);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    // reset state
    step(1'b0, 1'b0, 1'b1);
    // reset wins over a coin in the same cycle (R1)
    step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1);
    // sweep: each start credit x each input pair
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 4; k++) begin
        step(1'b0, 1'b0, 1'b1);
        if (s == 1) step(1'b1, 1'b0, 1'b0);
        if (s == 2) step(1'b0, 1'b1, 1'b0);
        if (s == 3) begin
          step(1'b0, 1'b1, 1'b0);
          step(1'b1, 1'b0, 1'b0);
        end
        step(k[0], k[1], 1'b0);
        step(1'b0, 1'b0, 1'b0); // hold afterwards
        step(1'b0, 1'b0, 1'b0);
      end
    end
    // reset out of the paid state while a dime arrives
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    // pseudo-random coin stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1] & lfsr[2], lfsr[7:3] == 5'd0);
    end
    finish_run();
  end
endmodule